// File: doc/BRIEF.md
# Pipelined Synchronous Burst Static RAM

This block is a behavioural model of a synchronous static RAM with registered inputs and a registered read path. Every control input is sampled on the rising clock edge. Three chip-select inputs and two burst-start strobes are decoded into four kinds of cycle: begin a burst, continue it, hold it at the same address (suspend), or deselect the device. A third strobe moves the burst address forward. A global write input and per-byte write inputs decide whether a cycle reads or writes, and which byte lanes a write touches.

The burst address comes from a small counter that is loaded with the start address. Its low bits step in one of two orders: an XOR (interleaved) order or a wrapping incrementing order. A static mode input picks the order. Read data leaves an output register one clock after the command is registered. The data bus is split into an input word, an output word and an output-enable flag. An asynchronous output-enable input can force the flag low at any time. A sleep input freezes the whole block, including its memory contents, until the sleep input is released.

Top module: `sync_burst_sram`

## Requirements
- R1: The chip is selected only when `sel_a_n_i`=0, `sel_b_i`=1 and `sel_c_n_i`=0. A cycle with either start strobe low while the chip is not selected is a deselect.
- R2: A begin cycle started by `start_cpu_n_i`=0 is always a read. `wr_all_n_i`, `wr_byte_en_n_i` and `byte_sel_n_i` have no effect on it, and the memory is unchanged.
- R3: A begin cycle started by `start_ctl_n_i`=0 with `start_cpu_n_i`=1 writes when the combined write request is active, and reads otherwise.
- R4: The combined write request is active when `wr_all_n_i`=0, or when `wr_byte_en_n_i`=0 and at least one bit of `byte_sel_n_i` is 0. If `wr_byte_en_n_i`=0 and every byte-select bit is 1, the cycle is a read.
- R5: With `wr_all_n_i`=0 all lanes are written. Otherwise only lane i is written whose `byte_sel_n_i[i]` is 0. Lane i is `din_i[8i+7:8i]`.
- R6: A cycle with both start strobes high continues an active burst. `next_n_i`=0 moves to the next burst address, and `next_n_i`=1 stays on the current address. Either kind of cycle reads or writes according to R4.
- R7: The upper address bits stay at the start value. The two low bits are start XOR count when `linear_i`=0, and (start + count) mod 4 when `linear_i`=1. The count is 0 on the begin cycle.
- R8: The data for a read registered on clock edge k is on `dout_o`, with `dout_en_o`=1, after edge k+1.
- R9: After a deselect, `dout_en_o` is 0 in the slot that follows. Continue cycles do nothing until the next begin cycle. A write or idle cycle also leaves `dout_en_o` at 0 in its slot.
- R10: A read registered directly after a write to the same address returns the newly written data.
- R11: `oe_n_i`=1 forces `dout_en_o` to 0 at once, without waiting for a clock edge.
- R12: While `sleep_i`=1, commands are ignored. The memory, the burst state, `dout_o` and `dout_en_o` all hold their values, and operation resumes where it stopped.
- R13: After the synchronous reset `rst`, `dout_en_o` is 0 and no burst is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sleep_i | input | 1 | Freeze all state while high |
| linear_i | input | 1 | Burst order: 0 interleaved, 1 incrementing |
| oe_n_i | input | 1 | Asynchronous output enable, active low |
| sel_a_n_i | input | 1 | Chip select, active low |
| sel_b_i | input | 1 | Chip select, active high |
| sel_c_n_i | input | 1 | Chip select, active low |
| start_cpu_n_i | input | 1 | Burst start strobe, read only, active low |
| start_ctl_n_i | input | 1 | Burst start strobe, read or write, active low |
| next_n_i | input | 1 | Advance burst address, active low |
| wr_all_n_i | input | 1 | Write all lanes, active low |
| wr_byte_en_n_i | input | 1 | Master enable for byte writes, active low |
| byte_sel_n_i | input | NB | Per-lane write selects, active low |
| addr_i | input | AW | Start address |
| din_i | input | DW | Write data |
| dout_o | output | DW | Registered read data |
| dout_en_o | output | 1 | Read data valid and driven |

## Verification
The bench aims at the places where decode slips usually hide. One is a processor-strobe begin with the global write low: a design that lets it write would corrupt the word that is read back. Another is a byte-write master enable with no lanes selected: a design that still counts it as a write would return no valid data in that slot. Interleaved and incrementing bursts are read back from unaligned start addresses. A swapped order or a carry into the upper bits would return a neighbour's word. The bench also checks the output slot after a deselect, and a read directly after a write to the same address, which would return stale data if the write landed late. Sleep is applied in the middle of a burst: a leak through sleep would either advance the burst address or commit the write attempted during sleep.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_DESEL = 2'd1,
    OP_READ  = 2'd2,
    OP_WRITE = 2'd3
  } sb_op_e;
endpackage

// File: rtl/sbsram_decode.sv
module sbsram_decode
  import sbsram_pkg::*;
#(
  parameter int NB = 4
) (
  input  logic          start_cpu_n,
  input  logic          start_ctl_n,
  input  logic          next_n,
  input  logic          sel_a_n,
  input  logic          sel_b,
  input  logic          sel_c_n,
  input  logic          wr_all_n,
  input  logic          wr_byte_en_n,
  input  logic [NB-1:0] byte_sel_n,
  input  logic          active,
  output logic          begin_o,
  output logic          desel_o,
  output logic          adv_o,
  output sb_op_e        op_o,
  output logic [NB-1:0] mask_o
);
  logic          selected;
  logic          start_any;
  logic          wr_req;
  logic [NB-1:0] lane_mask;

  assign selected  = ~sel_a_n & sel_b & ~sel_c_n;
  assign start_any = ~start_cpu_n | ~start_ctl_n;
  assign wr_req    = ~wr_all_n | (~wr_byte_en_n & ~(&byte_sel_n));

  always_comb begin
    if (!wr_all_n)          lane_mask = '1;
    else if (!wr_byte_en_n) lane_mask = ~byte_sel_n;
    else                    lane_mask = '0;
  end

  always_comb begin
    if (start_any) begin
      if (!selected)         op_o = OP_DESEL;
      else if (!start_cpu_n) op_o = OP_READ;
      else                   op_o = wr_req ? OP_WRITE : OP_READ;
    end else if (active) begin
      op_o = wr_req ? OP_WRITE : OP_READ;
    end else begin
      op_o = OP_IDLE;
    end
  end

  assign begin_o = start_any & selected;
  assign desel_o = start_any & ~selected;
  assign adv_o   = ~start_any & active & ~next_n;
  assign mask_o  = (op_o == OP_WRITE) ? lane_mask : '0;
endmodule

// File: rtl/sbsram_burst_seq.sv
module sbsram_burst_seq #(
  parameter int AW = 6,
  parameter int BB = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hold,
  input  logic          begin_i,
  input  logic          desel_i,
  input  logic          adv_i,
  input  logic          linear_i,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] addr_o,
  output logic          active_o
);
  logic [AW-1:0] base_q;
  logic [BB-1:0] cnt_q;
  logic [BB-1:0] cnt_nxt;
  logic          act_q;

  function automatic logic [BB-1:0] step_lo(input logic [BB-1:0] s,
                                             input logic [BB-1:0] c,
                                             input logic lin);
    return lin ? (s + c) : (s ^ c);
  endfunction

  assign cnt_nxt  = adv_i ? cnt_q + 1'b1 : cnt_q;
  assign active_o = act_q;
  assign addr_o   = begin_i ? addr_i
                  : {base_q[AW-1:BB], step_lo(base_q[BB-1:0], cnt_nxt, linear_i)};

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      cnt_q  <= '0;
      act_q  <= 1'b0;
    end else if (!hold) begin
      if (begin_i) begin
        base_q <= addr_i;
        cnt_q  <= '0;
        act_q  <= 1'b1;
      end else if (desel_i) begin
        act_q  <= 1'b0;
      end else begin
        cnt_q  <= cnt_nxt;
      end
    end
  end

  // R6: a suspend cycle keeps the burst position
  a_r6_suspend_holds: assert property (@(posedge clk) disable iff (rst)
    (!hold && act_q && !begin_i && !desel_i && !adv_i) |=> $stable(cnt_q));
  // R12: sleep freezes the burst state
  a_r12_burst_frozen: assert property (@(posedge clk) disable iff (rst)
    hold |=> ($stable(cnt_q) && $stable(act_q) && $stable(base_q)));
endmodule

// File: rtl/sbsram_array.sv
module sbsram_array #(
  parameter int AW = 6,
  parameter int DW = 32,
  parameter int NB = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en_i,
  input  logic          we_i,
  input  logic          rd_i,
  input  logic [NB-1:0] mask_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  localparam int LW    = DW / NB;
  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    logic [LW-1:0] mem_q [DEPTH];
    logic [LW-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (en_i && we_i && mask_i[g]) mem_q[addr_i] <= wdata_i[g*LW +: LW];
    end

    always_ff @(posedge clk) begin
      if (rst)              rd_q <= '0;
      else if (en_i && rd_i) rd_q <= mem_q[addr_i];
    end

    assign rdata_o[g*LW +: LW] = rd_q;
  end
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
  import sbsram_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 32,
  parameter int NB = 4,
  parameter int BB = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sleep_i,
  input  logic          linear_i,
  input  logic          oe_n_i,
  input  logic          sel_a_n_i,
  input  logic          sel_b_i,
  input  logic          sel_c_n_i,
  input  logic          start_cpu_n_i,
  input  logic          start_ctl_n_i,
  input  logic          next_n_i,
  input  logic          wr_all_n_i,
  input  logic          wr_byte_en_n_i,
  input  logic [NB-1:0] byte_sel_n_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] din_i,
  output logic [DW-1:0] dout_o,
  output logic          dout_en_o
);
  logic          begin_w, desel_w, adv_w, active_w;
  sb_op_e        op_w;
  logic [NB-1:0] mask_w;
  logic [AW-1:0] addr_w;

  sb_op_e        op_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] din_q;
  logic [NB-1:0] mask_q;
  logic          rd_q;

  sbsram_decode #(.NB(NB)) u_decode (
    .start_cpu_n (start_cpu_n_i),
    .start_ctl_n (start_ctl_n_i),
    .next_n      (next_n_i),
    .sel_a_n     (sel_a_n_i),
    .sel_b       (sel_b_i),
    .sel_c_n     (sel_c_n_i),
    .wr_all_n    (wr_all_n_i),
    .wr_byte_en_n(wr_byte_en_n_i),
    .byte_sel_n  (byte_sel_n_i),
    .active      (active_w),
    .begin_o     (begin_w),
    .desel_o     (desel_w),
    .adv_o       (adv_w),
    .op_o        (op_w),
    .mask_o      (mask_w)
  );

  sbsram_burst_seq #(.AW(AW), .BB(BB)) u_burst (
    .clk     (clk),
    .rst     (rst),
    .hold    (sleep_i),
    .begin_i (begin_w),
    .desel_i (desel_w),
    .adv_i   (adv_w),
    .linear_i(linear_i),
    .addr_i  (addr_i),
    .addr_o  (addr_w),
    .active_o(active_w)
  );

  // command register stage
  always_ff @(posedge clk) begin
    if (rst) begin
      op_q   <= OP_IDLE;
      addr_q <= '0;
      din_q  <= '0;
      mask_q <= '0;
    end else if (!sleep_i) begin
      op_q   <= op_w;
      addr_q <= addr_w;
      din_q  <= din_i;
      mask_q <= mask_w;
    end
  end

  sbsram_array #(.AW(AW), .DW(DW), .NB(NB)) u_array (
    .clk    (clk),
    .rst    (rst),
    .en_i   (~sleep_i),
    .we_i   (op_q == OP_WRITE),
    .rd_i   (op_q == OP_READ),
    .mask_i (mask_q),
    .addr_i (addr_q),
    .wdata_i(din_q),
    .rdata_o(dout_o)
  );

  // output slot register: valid only for a read
  always_ff @(posedge clk) begin
    if (rst)           rd_q <= 1'b0;
    else if (!sleep_i) rd_q <= (op_q == OP_READ);
  end

  assign dout_en_o = rd_q & ~oe_n_i;

  // R1: begin strobe while unselected becomes a deselect
  a_r1_unselected_desel: assert property (@(posedge clk) disable iff (rst)
    (!sleep_i && (!start_cpu_n_i || !start_ctl_n_i)
     && !(!sel_a_n_i && sel_b_i && !sel_c_n_i)) |=> (op_q == OP_DESEL));
  // R2: processor strobe begin is a read
  a_r2_cpu_start_reads: assert property (@(posedge clk) disable iff (rst)
    (!sleep_i && !start_cpu_n_i && !sel_a_n_i && sel_b_i && !sel_c_n_i)
    |=> (op_q == OP_READ));
  // R8: registered read drives the output slot one edge later
  a_r8_read_latency: assert property (@(posedge clk) disable iff (rst)
    (!sleep_i && op_q == OP_READ) |=> rd_q);
  // R9: non-read commands leave the slot undriven
  a_r9_no_drive: assert property (@(posedge clk) disable iff (rst)
    (!sleep_i && op_q != OP_READ) |=> !rd_q);
  // R10: full-word write followed by read of the same address
  a_r10_pass_through: assert property (@(posedge clk) disable iff (rst)
    (!sleep_i && op_q == OP_READ && $past(op_q) == OP_WRITE && $past(!sleep_i)
     && $past(addr_q) == addr_q && (&$past(mask_q))) |=> (dout_o == $past(din_q, 2)));
  // R12: sleep freezes outputs and command stage
  a_r12_sleep_holds: assert property (@(posedge clk) disable iff (rst)
    sleep_i |=> ($stable(dout_o) && $stable(rd_q) && $stable(op_q)));
endmodule

// File: tb/sync_burst_sram_tb_top.sv
`timescale 1ns/1ps
module sync_burst_sram_tb_top;
  localparam int AW = 6;
  localparam int DW = 32;
  localparam int NB = 4;
  localparam int BB = 2;
  localparam int LW = DW / NB;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst, sleep_i, linear_i, oe_n_i;
  logic          sel_a_n_i, sel_b_i, sel_c_n_i;
  logic          start_cpu_n_i, start_ctl_n_i, next_n_i;
  logic          wr_all_n_i, wr_byte_en_n_i;
  logic [NB-1:0] byte_sel_n_i;
  logic [AW-1:0] addr_i;
  logic [DW-1:0] din_i;
  logic [DW-1:0] dout_o;
  logic          dout_en_o;

  sync_burst_sram #(.AW(AW), .DW(DW), .NB(NB), .BB(BB)) dut_i (
    .clk(clk), .rst(rst), .sleep_i(sleep_i), .linear_i(linear_i), .oe_n_i(oe_n_i),
    .sel_a_n_i(sel_a_n_i), .sel_b_i(sel_b_i), .sel_c_n_i(sel_c_n_i),
    .start_cpu_n_i(start_cpu_n_i), .start_ctl_n_i(start_ctl_n_i), .next_n_i(next_n_i),
    .wr_all_n_i(wr_all_n_i), .wr_byte_en_n_i(wr_byte_en_n_i), .byte_sel_n_i(byte_sel_n_i),
    .addr_i(addr_i), .din_i(din_i), .dout_o(dout_o), .dout_en_o(dout_en_o)
  );

  int checks = 0;
  int errors = 0;
  int ecount = 0;
  bit done   = 1'b0;

  always @(posedge clk) ecount <= ecount + 1;

  typedef struct {
    bit            cpu_n, ctl_n, nxt_n, a_n, b, c_n, gw_n, bwe_n, sleep, oe_n;
    logic [NB-1:0] bsel_n;
    logic [AW-1:0] addr;
    logic [DW-1:0] din;
    string         tag;
  } cmd_t;

  typedef struct {
    int            due;
    bit            en;
    logic [DW-1:0] data;
    string         tag;
  } exp_t;

  exp_t q[$];

  // requirement-level model
  logic [DW-1:0] mem_m [DEPTH];
  bit            act_m = 1'b0;
  logic [AW-1:0] base_m = '0;
  logic [BB-1:0] cnt_m = '0;
  bit            st_en = 1'b0, out_en = 1'b0;
  logic [DW-1:0] st_data = '0, out_data = '0;
  string         st_tag = "R13", out_tag = "R13";

  function automatic cmd_t nop(input string tag);
    cmd_t c;
    c.cpu_n = 1; c.ctl_n = 1; c.nxt_n = 1;
    c.a_n = 0; c.b = 1; c.c_n = 0;
    c.gw_n = 1; c.bwe_n = 1; c.bsel_n = '1;
    c.sleep = 0; c.oe_n = 0;
    c.addr = '0; c.din = '0; c.tag = tag;
    return c;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input cmd_t c);
    bit sel, beg, wr;
    bit is_rd, is_wr;
    logic [NB-1:0] mask;
    logic [AW-1:0] a;
    logic [BB-1:0] lo;
    sleep_i = c.sleep; oe_n_i = c.oe_n;
    sel_a_n_i = c.a_n; sel_b_i = c.b; sel_c_n_i = c.c_n;
    start_cpu_n_i = c.cpu_n; start_ctl_n_i = c.ctl_n; next_n_i = c.nxt_n;
    wr_all_n_i = c.gw_n; wr_byte_en_n_i = c.bwe_n; byte_sel_n_i = c.bsel_n;
    addr_i = c.addr; din_i = c.din;
    if (!c.sleep) begin
      sel  = !c.a_n && c.b && !c.c_n;
      beg  = !c.cpu_n || !c.ctl_n;
      wr   = !c.gw_n || (!c.bwe_n && (c.bsel_n != '1));
      mask = !c.gw_n ? '1 : (!c.bwe_n ? ~c.bsel_n : '0);
      is_rd = 0; is_wr = 0; a = '0;
      if (beg) begin
        if (!sel) act_m = 0;
        else begin
          act_m = 1; base_m = c.addr; cnt_m = '0; a = c.addr;
          if (!c.cpu_n) is_rd = 1;
          else begin is_wr = wr; is_rd = !wr; end
        end
      end else if (act_m) begin
        if (!c.nxt_n) cnt_m = cnt_m + 1'b1;
        lo = linear_i ? base_m[BB-1:0] + cnt_m : base_m[BB-1:0] ^ cnt_m;
        a = {base_m[AW-1:BB], lo};
        is_wr = wr; is_rd = !wr;
      end
      out_en = st_en; out_data = st_data; out_tag = st_tag;
      st_en = is_rd; st_data = is_rd ? mem_m[a] : '0; st_tag = c.tag;
      if (is_wr)
        for (int i = 0; i < NB; i++)
          if (mask[i]) mem_m[a][i*LW +: LW] = c.din[i*LW +: LW];
    end
    q.push_back('{ecount + 1, out_en, out_data, out_tag});
    @(negedge clk); #1;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (q.size() > 0 && q[0].due == ecount) begin
      exp_t e;
      bit en_exp;
      e = q.pop_front();
      en_exp = e.en && !oe_n_i;
      chk(dout_en_o == en_exp, {e.tag, " output enable"}, {31'd0, dout_en_o}, {31'd0, en_exp});
      if (en_exp) chk(dout_o === e.data, {e.tag, " read data"}, dout_o, e.data);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic deselect(input string tag);
    cmd_t c;
    c = nop(tag); c.ctl_n = 0; c.a_n = 1;
    step(c);
  endtask

  initial begin
    cmd_t c;
    rst = 1'b1; linear_i = 1'b0;
    c = nop("R13");
    sleep_i = 0; oe_n_i = 0; sel_a_n_i = 0; sel_b_i = 1; sel_c_n_i = 0;
    start_cpu_n_i = 1; start_ctl_n_i = 1; next_n_i = 1;
    wr_all_n_i = 1; wr_byte_en_n_i = 1; byte_sel_n_i = '1; addr_i = '0; din_i = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0; #1;
    // R13: reset leaves the output undriven and no burst active
    chk(dout_en_o == 1'b0, "R13 reset enable", {31'd0, dout_en_o}, '0);
    step(nop("R13")); step(nop("R13")); step(nop("R13"));

    // R3/R5/R7 interleaved write burst from address 9, full-word writes
    c = nop("R3"); c.ctl_n = 0; c.gw_n = 0; c.addr = 6'd9; c.din = 32'hA000_0009; step(c);
    for (int i = 1; i < 4; i++) begin
      c = nop("R6"); c.nxt_n = 0; c.gw_n = 0; c.din = 32'hA000_0100 + i; step(c);
    end
    // R7 interleaved read-back: 9, 8, 11, 10
    c = nop("R2"); c.cpu_n = 0; c.addr = 6'd9; step(c);
    for (int i = 1; i < 4; i++) begin
      c = nop("R7"); c.nxt_n = 0; step(c);
    end
    // R10 write then immediate read of the same address
    c = nop("R10"); c.ctl_n = 0; c.gw_n = 0; c.addr = 6'd20; c.din = 32'h1234_5678; step(c);
    c = nop("R10"); c.cpu_n = 0; c.addr = 6'd20; step(c);
    deselect("R9"); step(nop("R9")); step(nop("R9"));

    // R7 incrementing order from address 14: 14, 15, 12, 13
    linear_i = 1'b1;
    c = nop("R3"); c.ctl_n = 0; c.gw_n = 0; c.addr = 6'd14; c.din = 32'hB000_000E; step(c);
    for (int i = 1; i < 4; i++) begin
      c = nop("R7"); c.nxt_n = 0; c.gw_n = 0; c.din = 32'hB000_0200 + i; step(c);
    end
    c = nop("R3"); c.ctl_n = 0; c.addr = 6'd14; step(c);
    for (int i = 1; i < 4; i++) begin
      c = nop("R7"); c.nxt_n = 0; step(c);
    end

    // R5 byte lanes: full word, then lanes 0 and 2 only
    c = nop("R5"); c.ctl_n = 0; c.gw_n = 0; c.addr = 6'd30; c.din = 32'hFFFF_FFFF; step(c);
    c = nop("R5"); c.ctl_n = 0; c.bwe_n = 0; c.bsel_n = 4'b1010; c.addr = 6'd30; c.din = 32'h1122_3344; step(c);
    c = nop("R5"); c.cpu_n = 0; c.addr = 6'd30; step(c);
    // R4 master enable with no lane selected is a read
    c = nop("R4"); c.ctl_n = 0; c.bwe_n = 0; c.bsel_n = 4'b1111; c.addr = 6'd30; c.din = 32'h0; step(c);
    // R4 lanes selected but master enable high is a read
    c = nop("R4"); c.ctl_n = 0; c.bwe_n = 1; c.bsel_n = 4'b0000; c.addr = 6'd30; c.din = 32'h0; step(c);
    // R2 processor strobe with global write low must not write
    c = nop("R2"); c.cpu_n = 0; c.gw_n = 0; c.addr = 6'd30; c.din = 32'hDEAD_BEEF; step(c);
    c = nop("R2"); c.cpu_n = 0; c.addr = 6'd30; step(c);

    // R6 suspend: stays on the start address
    c = nop("R6"); c.cpu_n = 0; c.addr = 6'd20; step(c);
    step(nop("R6")); step(nop("R6"));

    // R1/R9 deselect through each select input, continues stay idle
    deselect("R1");
    c = nop("R9"); c.nxt_n = 0; step(c);
    c = nop("R9"); c.nxt_n = 0; step(c);
    c = nop("R1"); c.cpu_n = 0; c.b = 0; step(c);
    c = nop("R1"); c.ctl_n = 0; c.c_n = 1; step(c);
    step(nop("R9")); step(nop("R9"));

    // R11 output enable high suppresses a pending read
    c = nop("R11"); c.cpu_n = 0; c.addr = 6'd20; step(c);
    c = nop("R11"); c.oe_n = 1; step(c);
    step(nop("R11"));
    oe_n_i = 1'b1; #1;
    chk(dout_en_o == 1'b0, "R11 async disable", {31'd0, dout_en_o}, '0);
    oe_n_i = 1'b0; #1;
    chk(dout_en_o == 1'b1, "R11 async enable", {31'd0, dout_en_o}, 32'd1);

    // R12 sleep during a burst; write attempted during sleep is ignored
    c = nop("R12"); c.cpu_n = 0; c.addr = 6'd8; step(c);
    for (int i = 0; i < 3; i++) begin
      c = nop("R12"); c.sleep = 1; c.ctl_n = 0; c.gw_n = 0; c.addr = 6'd8; c.din = 32'h5555_5555; step(c);
    end
    c = nop("R12"); c.nxt_n = 0; step(c);
    c = nop("R12"); c.sleep = 1; c.nxt_n = 0; step(c);
    c = nop("R12"); c.nxt_n = 0; step(c);
    c = nop("R12"); c.cpu_n = 0; c.addr = 6'd8; step(c);
    deselect("R9"); step(nop("R9")); step(nop("R9")); step(nop("R9"));

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule